// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash. Each bus write reaches it as a one-cycle strobe carrying a 19-bit address and a data byte. The block checks these writes against fixed unlock patterns. A matching multi-write sequence either launches an embedded operation or switches the read path into identifier mode. The supported embedded operations are byte program, whole-array erase and single-sector erase. Only the low 15 address bits take part in matching the unlock and command cycles.

When an operation is launched, the block raises a one-cycle start pulse. The pulse comes with a 2-bit operation code and the address and data of the final write. The block then stays busy until the array engine reports completion, and ignores every write in the meantime. Any write that does not fit the expected sequence drops the decoder back to plain read mode. In identifier mode, a small read port returns the maker code and the device code, each with odd parity.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode: start_o is 0, busy_o is 0, id_mode_o is 0 and id_code_o is 00h.
- R2: Only address bits 14:0 are compared for the unlock and command cycles. Bits 18:15 of those writes have no effect. The first unlock cycle is AAh at 5555h and the second is 55h at 2AAAh.
- R3: Unlock, unlock, then A0h at 5555h, then any write W. This sequence gives start_o high for exactly the cycle after W, with op_code_o = 00 and op_addr_o/op_data_o equal to the address and data of W.
- R4: Unlock, unlock, 80h at 5555h, unlock, unlock, then 10h at 5555h. This sequence starts a chip erase with op_code_o = 01, op_data_o = 10h and op_addr_o[14:0] = 5555h.
- R5: The same six-write form ending in 30h at any address starts a sector erase. It gives op_code_o = 10, op_data_o = 30h and op_addr_o equal to that full address, so op_addr_o[18:16] names the sector.
- R6: Unlock, unlock, then 90h at 5555h sets id_mode_o. In identifier mode, rd_offset_i = 0 returns DAh, rd_offset_i = 1 returns D6h, and offsets 2 and 3 return 00h. The two codes have odd parity over all 8 bits.
- R7: In identifier mode, unlock, unlock, then F0h at 5555h clears id_mode_o. The flag stays high during the two unlock writes.
- R8: In identifier mode, a single write of F0h at any address clears id_mode_o.
- R9: A write whose address or data does not match the next expected cycle returns the decoder to read mode. This applies inside identifier mode as well. Such a write starts nothing, and a later command must begin again with the first unlock cycle.
- R10: Each start sets busy_o in the same cycle as the pulse. busy_o stays high, and writes start nothing, until op_done_i is seen. The decoder then returns to read mode in the next cycle. op_done_i outside busy has no effect.
- R11: The start pulse lasts one cycle, and op_code_o is never 11 while start_o is high.
- R12: busy_o and id_mode_o are never high together, and id_code_o is 00h whenever id_mode_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb_i | input | 1 | One-cycle bus write strobe |
| wr_addr_i | input | 19 | Write address |
| wr_data_i | input | 8 | Write data byte |
| op_done_i | input | 1 | Embedded operation finished |
| rd_offset_i | input | 2 | Identifier read offset (address bits 1:0) |
| start_o | output | 1 | One-cycle operation start pulse |
| op_code_o | output | 2 | 00 program, 01 chip erase, 10 sector erase |
| op_addr_o | output | 19 | Address of the launching write |
| op_data_o | output | 8 | Data of the launching write |
| busy_o | output | 1 | Embedded operation in progress |
| id_mode_o | output | 1 | Identifier read mode active |
| id_code_o | output | 8 | Identifier byte for rd_offset_i, 00h outside identifier mode |

## Verification
The assertions assume that op_done_i is a one-cycle pulse and that each write is a single-cycle strobe with known address and data. Under these assumptions the exit, exclusivity and pulse-width properties describe whole transactions. The bench respects this: each write strobe is followed by an idle cycle, and op_done_i is raised for exactly one cycle. Random stimulus is built from complete command sequences with randomised upper address bits. Some cycles are corrupted at random, and some writes land while the block is busy. This keeps the stimulus legal at the ports while still reaching every abort path.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int KEY_W = 15;

    localparam logic [KEY_W-1:0] KEY_ADDR = 15'h5555;
    localparam logic [KEY_W-1:0] ALT_ADDR = 15'h2AAA;

    localparam logic [7:0] B_UNL1  = 8'hAA;
    localparam logic [7:0] B_UNL2  = 8'h55;
    localparam logic [7:0] B_PGM   = 8'hA0;
    localparam logic [7:0] B_ERS   = 8'h80;
    localparam logic [7:0] B_CHIP  = 8'h10;
    localparam logic [7:0] B_SECT  = 8'h30;
    localparam logic [7:0] B_IDENT = 8'h90;
    localparam logic [7:0] B_EXIT  = 8'hF0;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_ERS_ARM,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_PGM_ARG,
        ST_IDENT,
        ST_ID_UNL1,
        ST_ID_UNL2,
        ST_BUSY
    } dec_state_e;

    typedef enum logic [1:0] {
        OP_PROGRAM      = 2'b00,
        OP_CHIP_ERASE   = 2'b01,
        OP_SECTOR_ERASE = 2'b10
    } op_kind_e;

    typedef struct packed {
        logic at_key;
        logic at_alt;
        logic d_unl1;
        logic d_unl2;
        logic d_pgm;
        logic d_ers;
        logic d_chip;
        logic d_sect;
        logic d_ident;
        logic d_exit;
    } cyc_hit_t;

endpackage

// File: rtl/flash_cyc_match.sv
module flash_cyc_match
    import flash_cmd_pkg::*;
#(
    parameter int CMP_W  = KEY_W,
    parameter int DATA_W = 8
) (
    input  logic [CMP_W-1:0]  addr_low_i,
    input  logic [DATA_W-1:0] data_i,
    output cyc_hit_t          hit_o
);

    always_comb begin
        hit_o.at_key  = (addr_low_i == CMP_W'(KEY_ADDR));
        hit_o.at_alt  = (addr_low_i == CMP_W'(ALT_ADDR));
        hit_o.d_unl1  = (data_i == B_UNL1);
        hit_o.d_unl2  = (data_i == B_UNL2);
        hit_o.d_pgm   = (data_i == B_PGM);
        hit_o.d_ers   = (data_i == B_ERS);
        hit_o.d_chip  = (data_i == B_CHIP);
        hit_o.d_sect  = (data_i == B_SECT);
        hit_o.d_ident = (data_i == B_IDENT);
        hit_o.d_exit  = (data_i == B_EXIT);
    end

endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
    parameter logic [6:0] MAKER_BASE = 7'h5A,
    parameter logic [6:0] DEV_BASE   = 7'h56
) (
    input  logic       en_i,
    input  logic [1:0] offset_i,
    output logic [7:0] code_o
);

    localparam logic [7:0] MAKER_CODE = {~(^MAKER_BASE), MAKER_BASE};
    localparam logic [7:0] DEV_CODE   = {~(^DEV_BASE), DEV_BASE};

    always_comb begin
        code_o = 8'h00;
        if (en_i) begin
            case (offset_i)
                2'd0:    code_o = MAKER_CODE;
                2'd1:    code_o = DEV_CODE;
                default: code_o = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  cyc_hit_t          hit_i,
    input  logic              op_done_i,
    output logic              start_o,
    output op_kind_e          op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              busy_o,
    output logic              id_mode_o
);

    typedef struct packed {
        dec_state_e        st;
        logic              start;
        op_kind_e          op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st:    ST_READ,
        start: 1'b0,
        op:    OP_PROGRAM,
        addr:  '0,
        data:  '0
    };

    regs_t r_d, r_q;

    logic unl1_ok, unl2_ok;
    assign unl1_ok = hit_i.at_key & hit_i.d_unl1;
    assign unl2_ok = hit_i.at_alt & hit_i.d_unl2;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        case (r_q.st)
            ST_READ: begin
                if (wr_stb_i) r_d.st = unl1_ok ? ST_UNL1 : ST_READ;
            end
            ST_UNL1: begin
                if (wr_stb_i) r_d.st = unl2_ok ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (wr_stb_i) begin
                    if (hit_i.at_key && hit_i.d_pgm)        r_d.st = ST_PGM_ARG;
                    else if (hit_i.at_key && hit_i.d_ers)   r_d.st = ST_ERS_ARM;
                    else if (hit_i.at_key && hit_i.d_ident) r_d.st = ST_IDENT;
                    else                                    r_d.st = ST_READ;
                end
            end
            ST_ERS_ARM: begin
                if (wr_stb_i) r_d.st = unl1_ok ? ST_ERS_UNL1 : ST_READ;
            end
            ST_ERS_UNL1: begin
                if (wr_stb_i) r_d.st = unl2_ok ? ST_ERS_UNL2 : ST_READ;
            end
            ST_ERS_UNL2: begin
                if (wr_stb_i) begin
                    r_d.st = ST_READ;
                    if (hit_i.at_key && hit_i.d_chip) begin
                        r_d.st    = ST_BUSY;
                        r_d.start = 1'b1;
                        r_d.op    = OP_CHIP_ERASE;
                        r_d.addr  = wr_addr_i;
                        r_d.data  = wr_data_i;
                    end else if (hit_i.d_sect) begin
                        r_d.st    = ST_BUSY;
                        r_d.start = 1'b1;
                        r_d.op    = OP_SECTOR_ERASE;
                        r_d.addr  = wr_addr_i;
                        r_d.data  = wr_data_i;
                    end
                end
            end
            ST_PGM_ARG: begin
                if (wr_stb_i) begin
                    r_d.st    = ST_BUSY;
                    r_d.start = 1'b1;
                    r_d.op    = OP_PROGRAM;
                    r_d.addr  = wr_addr_i;
                    r_d.data  = wr_data_i;
                end
            end
            ST_IDENT: begin
                if (wr_stb_i) begin
                    if (hit_i.d_exit)  r_d.st = ST_READ;
                    else if (unl1_ok)  r_d.st = ST_ID_UNL1;
                    else               r_d.st = ST_READ;
                end
            end
            ST_ID_UNL1: begin
                if (wr_stb_i) r_d.st = unl2_ok ? ST_ID_UNL2 : ST_READ;
            end
            ST_ID_UNL2: begin
                if (wr_stb_i) r_d.st = ST_READ;
            end
            ST_BUSY: begin
                if (op_done_i) r_d.st = ST_READ;
            end
            default: r_d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign start_o   = r_q.start;
    assign op_o      = r_q.op;
    assign addr_o    = r_q.addr;
    assign data_o    = r_q.data;
    assign busy_o    = (r_q.st == ST_BUSY);
    assign id_mode_o = (r_q.st == ST_IDENT) || (r_q.st == ST_ID_UNL1) ||
                       (r_q.st == ST_ID_UNL2);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              op_done_i,
    input  logic [1:0]        rd_offset_i,
    output logic              start_o,
    output logic [1:0]        op_code_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output logic [DATA_W-1:0] op_data_o,
    output logic              busy_o,
    output logic              id_mode_o,
    output logic [7:0]        id_code_o
);

    cyc_hit_t hit;
    op_kind_e op_kind;

    flash_cyc_match #(
        .CMP_W  (KEY_W),
        .DATA_W (DATA_W)
    ) u_match (
        .addr_low_i (wr_addr_i[KEY_W-1:0]),
        .data_i     (wr_data_i),
        .hit_o      (hit)
    );

    flash_cmd_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .hit_i     (hit),
        .op_done_i (op_done_i),
        .start_o   (start_o),
        .op_o      (op_kind),
        .addr_o    (op_addr_o),
        .data_o    (op_data_o),
        .busy_o    (busy_o),
        .id_mode_o (id_mode_o)
    );

    flash_id_rom u_rom (
        .en_i     (id_mode_o),
        .offset_i (rd_offset_i),
        .code_o   (id_code_o)
    );

    assign op_code_o = op_kind;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic              op_done,
    input logic [1:0]        rd_offset,
    input logic              start,
    input logic [1:0]        op_code,
    input logic [14:0]       op_key_addr,
    input logic [DATA_W-1:0] op_data,
    input logic              busy,
    input logic              id_mode,
    input logic [7:0]        id_code
);

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    p_opcode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> op_code != 2'b11);

    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> busy);

    p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done) |=> (busy && !start));

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done) |=> (!busy && !id_mode && !start));

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && id_mode));

    p_idzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> id_code == 8'h00);

    p_maker_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && rd_offset == 2'd0) |-> id_code == 8'hDA);

    p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && !rd_offset[1]) |-> (^id_code) == 1'b1);

    p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && wr_stb && wr_data == 8'hF0) |=> !id_mode);

    p_chip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_code == 2'b01) |-> (op_data == 8'h10 && op_key_addr == 15'h5555));

    p_sector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_code == 2'b10) |-> op_data == 8'h30);

endmodule

bind flash_cmd_decoder flash_cmd_checker #(
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb_i),
    .wr_data     (wr_data_i),
    .op_done     (op_done_i),
    .rd_offset   (rd_offset_i),
    .start       (start_o),
    .op_code     (op_code_o),
    .op_key_addr (op_addr_o[14:0]),
    .op_data     (op_data_o),
    .busy        (busy_o),
    .id_mode     (id_mode_o),
    .id_code     (id_code_o)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb_i = 1'b0;
    logic [18:0] wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        op_done_i = 1'b0;
    logic [1:0]  rd_offset_i = '0;
    logic        start_o;
    logic [1:0]  op_code_o;
    logic [18:0] op_addr_o;
    logic [7:0]  op_data_o;
    logic        busy_o;
    logic        id_mode_o;
    logic [7:0]  id_code_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // reference model: 0 read,1 u1,2 u2,3 erase armed,4 eu1,5 eu2,
    // 6 program arg,7 ident,8 id u1,9 id u2,10 busy
    int          ms = 0;
    bit          e_start;
    logic [1:0]  e_op;
    logic [18:0] e_addr;
    logic [7:0]  e_data;

    always #5 clk = ~clk;

    flash_cmd_decoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb_i    (wr_stb_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .op_done_i   (op_done_i),
        .rd_offset_i (rd_offset_i),
        .start_o     (start_o),
        .op_code_o   (op_code_o),
        .op_addr_o   (op_addr_o),
        .op_data_o   (op_data_o),
        .busy_o      (busy_o),
        .id_mode_o   (id_mode_o),
        .id_code_o   (id_code_o)
    );

    function automatic logic [7:0] exp_id(input int st, input logic [1:0] off);
        if (st < 7 || st > 9) return 8'h00;
        if (off == 2'd0) return 8'hDA;
        if (off == 2'd1) return 8'hD6;
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_wr(input logic [18:0] a, input logic [7:0] d);
        bit key, alt;
        key = (a[14:0] == 15'h5555);
        alt = (a[14:0] == 15'h2AAA);
        e_start = 1'b0;
        case (ms)
            0: ms = (key && d == 8'hAA) ? 1 : 0;
            1: ms = (alt && d == 8'h55) ? 2 : 0;
            2: if (key && d == 8'hA0) ms = 6;
               else if (key && d == 8'h80) ms = 3;
               else if (key && d == 8'h90) ms = 7;
               else ms = 0;
            3: ms = (key && d == 8'hAA) ? 4 : 0;
            4: ms = (alt && d == 8'h55) ? 5 : 0;
            5: if (key && d == 8'h10) begin
                   e_start = 1; e_op = 2'b01; e_addr = a; e_data = d; ms = 10;
               end else if (d == 8'h30) begin
                   e_start = 1; e_op = 2'b10; e_addr = a; e_data = d; ms = 10;
               end else ms = 0;
            6: begin e_start = 1; e_op = 2'b00; e_addr = a; e_data = d; ms = 10; end
            7: if (d == 8'hF0) ms = 0;
               else if (key && d == 8'hAA) ms = 8;
               else ms = 0;
            8: ms = (alt && d == 8'h55) ? 9 : 0;
            9: ms = 0;
            default: ms = 10;
        endcase
    endtask

    task automatic compare(input string tag);
        chk({tag, " start"}, 32'(start_o), 32'(e_start));
        chk({tag, " busy"}, 32'(busy_o), 32'(ms == 10));
        chk({tag, " id_mode"}, 32'(id_mode_o), 32'(ms >= 7 && ms <= 9));
        chk({tag, " id_code"}, 32'(id_code_o), 32'(exp_id(ms, rd_offset_i)));
        if (e_start) begin
            chk({tag, " op_code"}, 32'(op_code_o), 32'(e_op));
            chk({tag, " op_addr"}, 32'(op_addr_o), 32'(e_addr));
            chk({tag, " op_data"}, 32'(op_data_o), 32'(e_data));
        end
    endtask

    task automatic wr(input string tag, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb_i    = 1'b1;
        wr_addr_i   = a;
        wr_data_i   = d;
        rd_offset_i = 2'($urandom % 4);
        @(negedge clk);
        wr_stb_i = 1'b0;
        model_wr(a, d);
        compare(tag);
        e_start = 1'b0;
    endtask

    task automatic done_pulse(input string tag);
        @(negedge clk);
        op_done_i = 1'b1;
        @(negedge clk);
        op_done_i = 1'b0;
        if (ms == 10) ms = 0;
        e_start = 1'b0;
        compare(tag);
    endtask

    task automatic unlock(input string tag, input logic [3:0] hi);
        wr(tag, {hi, 15'h5555}, 8'hAA);
        wr(tag, {hi, 15'h2AAA}, 8'h55);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0F1A));
        e_start = 0; e_op = 0; e_addr = 0; e_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compare("R1 reset");

        // R2 R3: unlock with upper address bits set, then program
        unlock("R2 upper bits", 4'hF);
        wr("R3 program setup", 19'h05555, 8'hA0);
        wr("R3 program launch", 19'h4_1234, 8'h5C);
        // R11: pulse is one cycle wide
        @(negedge clk);
        chk("R11 pulse width", 32'(start_o), 32'd0);
        // R10: writes ignored while busy
        unlock("R10 busy ignore", 4'h0);
        wr("R10 busy ignore", 19'h05555, 8'hA0);
        wr("R10 busy ignore", 19'h00001, 8'h00);
        done_pulse("R10 release");
        // R10: op_done outside busy has no effect
        done_pulse("R10 stray done");

        // R4: chip erase
        unlock("R4 chip", 4'h3);
        wr("R4 chip", 19'h05555, 8'h80);
        unlock("R4 chip", 4'h8);
        wr("R4 chip launch", 19'h2D555, 8'h10);
        done_pulse("R4 release");

        // R5: sector erase at sector 5
        unlock("R5 sector", 4'h0);
        wr("R5 sector", 19'h05555, 8'h80);
        unlock("R5 sector", 4'h0);
        wr("R5 sector launch", 19'h5_ABCD, 8'h30);
        chk("R5 sector field", 32'(op_addr_o[18:16]), 32'd5);
        done_pulse("R5 release");

        // R6 R7: identifier entry, all offsets, three-write exit
        unlock("R6 ident", 4'h0);
        wr("R6 ident enter", 19'h05555, 8'h90);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rd_offset_i = 2'(k);
            #1;
            chk("R6 id offset", 32'(id_code_o), 32'(exp_id(7, 2'(k))));
        end
        unlock("R7 ident exit", 4'h1);
        wr("R7 ident exit", 19'h05555, 8'hF0);

        // R8: single-write exit at arbitrary address
        unlock("R8 ident", 4'h0);
        wr("R8 ident enter", 19'h05555, 8'h90);
        wr("R8 single exit", 19'h1_2345, 8'hF0);

        // R9: wrong third cycle aborts, later writes start nothing
        unlock("R9 abort", 4'h0);
        wr("R9 wrong cycle", 19'h05555, 8'h55);
        wr("R9 no resume", 19'h05555, 8'hA0);
        wr("R9 no start", 19'h00100, 8'h12);
        // R9: wrong write in identifier mode leaves it
        unlock("R9 ident", 4'h0);
        wr("R9 ident enter", 19'h05555, 8'h90);
        wr("R9 ident wrong", 19'h00000, 8'h33);
        // R12 checked through compare (id_code zero outside identifier mode)

        // random command streams with corruption
        for (int n = 0; n < 500; n++) begin
            int kind;
            int len;
            logic [18:0] ca [6];
            logic [7:0]  cd [6];
            kind = int'($urandom % 6);
            ca[0] = {4'($urandom), 15'h5555}; cd[0] = 8'hAA;
            ca[1] = {4'($urandom), 15'h2AAA}; cd[1] = 8'h55;
            ca[2] = {4'($urandom), 15'h5555};
            ca[3] = {4'($urandom), 15'h5555}; cd[3] = 8'hAA;
            ca[4] = {4'($urandom), 15'h2AAA}; cd[4] = 8'h55;
            ca[5] = 19'($urandom);            cd[5] = 8'($urandom);
            len = 3;
            case (kind)
                0: begin cd[2] = 8'hA0; ca[3] = 19'($urandom); cd[3] = 8'($urandom); len = 4; end
                1: begin cd[2] = 8'h80; ca[5] = {4'($urandom), 15'h5555}; cd[5] = 8'h10; len = 6; end
                2: begin cd[2] = 8'h80; cd[5] = 8'h30; len = 6; end
                3: cd[2] = 8'h90;
                4: cd[2] = 8'hF0;
                default: begin ca[0] = 19'($urandom); cd[0] = 8'hF0; len = 1; end
            endcase
            for (int c = 0; c < len; c++) begin
                logic [18:0] a;
                logic [7:0]  d;
                a = ca[c];
                d = cd[c];
                if ($urandom % 10 == 0) d = d ^ 8'(1 + $urandom % 255);
                if ($urandom % 12 == 0) a[3:0] = a[3:0] ^ 4'(1 + $urandom % 15);
                wr("R9 random", a, d);
                if (ms == 10) begin
                    for (int j = 0; j < int'($urandom % 3); j++)
                        wr("R10 random busy", 19'($urandom), 8'($urandom));
                    done_pulse("R10 random release");
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule